// File: doc/BRIEF.md
# ALU Power Gating Controller

This block decides, unit by unit, when the adders and multipliers of an execution cluster are switched off and when they are brought back. Every unit keeps a count of consecutive cycles in which it received no work. Software can ask for a unit to be put to sleep with a command carrying its index. That request is honoured only once the unit has been idle long enough. A unit that stays unused for a much longer time is switched off by the hardware without any command.

When the scheduler aims an operation at a switched-off unit, the block restores power first. It then waits out a programmable settling interval and only after that marks the unit ready. During that time it raises a stall so that the scheduler holds the operation back. The gate enable of each unit drives the external power switch. The ready flag of each unit tells the scheduler whether it may issue to that unit.

Top module: `alu_pg_ctrl`

## Requirements
- R1: While rst_ni is low and right after reset, every unit is in state ON (code 00), every gate_en_o and ready_o bit is 1 and stall_o is 0.
- R2: Units are indexed with adders at 0..N_ADD-1 and multipliers at N_ADD..N_ADD+N_MUL-1. Gating one unit leaves every other unit's state, gate enable and ready flag unchanged.
- R3: The idle count of a unit in ON rises by one on every clock edge at which no issue is accepted for it. An accepted issue resets it to zero. A unit whose count reaches AUTO_LIMIT (default 1000) goes to GATED at that edge without any command.
- R4: A sleep command (sleep_valid_i with sleep_unit_i) for an ON unit whose idle count already exceeds IDLE_MIN (default 100) moves it to GATED on the next edge.
- R5: A sleep command for an ON unit with idle count of IDLE_MIN or less is held pending. The unit goes to GATED on the first edge at which its count would exceed IDLE_MIN, which is the 101st consecutive idle edge by default. An issue accepted by the unit before then cancels the pending sleep.
- R6: unit_state_o bits [2i+1:2i] give the state of unit i: 00 ON, 01 GATED, 10 WAKING. gate_en_o[i] is 0 only in GATED. ready_o[i] is 1 only in ON.
- R7: An issue aimed at a GATED unit moves it to WAKING on the next edge. The unit stays in WAKING for exactly S cycles, where S is the settling value in force when the wake began. It then returns to ON with its idle count at zero.
- R8: stall_o is 1 exactly when issue_valid_i is high and issue_unit_i names an existing unit whose ready flag is 0. An issue is accepted only by an ON unit.
- R9: The settling register resets to 4. A write (settle_we_i) stores settle_val_i clamped into the range 1 to 10, and the stored value applies to wakes that start after the write.
- R10: A sleep command for a unit in GATED or WAKING has no effect and leaves no pending sleep behind. Commands whose index does not name a unit change no state and raise no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Scheduler presents an operation this cycle |
| issue_unit_i | input | UW | Index of the unit the operation targets |
| sleep_valid_i | input | 1 | Sleep command present |
| sleep_unit_i | input | UW | Index of the unit to put to sleep |
| settle_we_i | input | 1 | Write strobe for the settling register |
| settle_val_i | input | SETTLE_W | Settling cycles to store (clamped to 1..10) |
| gate_en_o | output | N_UNITS | Power switch enable per unit, 1 = powered |
| ready_o | output | N_UNITS | Unit may accept an operation |
| unit_state_o | output | 2*N_UNITS | Two-bit state per unit |
| stall_o | output | 1 | Hold back the presented operation |

## Verification
State, gate enable and ready flag follow one edge after the input that causes them. A sleep for an already idle unit lands one edge later, while a pending sleep lands on the 101st idle edge after the last accepted issue. A woken unit reads WAKING for S sampled cycles and ON on the S+1th, and stall is combinational on the issue inputs and the unit's current ready flag. The bench's driver stamps every expected item with the absolute cycle number worked out from these delays. The monitor compares only at that cycle, two nanoseconds after the edge, while the inputs stay fixed from the preceding falling edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_ON     = 2'b00,
    PG_GATED  = 2'b01,
    PG_WAKING = 2'b10
  } pg_state_e;
endpackage

// File: rtl/pg_settle_reg.sv
module pg_settle_reg #(
  parameter int SETTLE_W   = 4,
  parameter int SETTLE_MIN = 1,
  parameter int SETTLE_MAX = 10,
  parameter int SETTLE_RST = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SETTLE_W-1:0] val_i,
  output logic [SETTLE_W-1:0] settle_o
);
  localparam logic [SETTLE_W-1:0] LO  = SETTLE_W'(SETTLE_MIN);
  localparam logic [SETTLE_W-1:0] HI  = SETTLE_W'(SETTLE_MAX);
  localparam logic [SETTLE_W-1:0] RST = SETTLE_W'(SETTLE_RST);

  logic [SETTLE_W-1:0] settle_q, clamped;

  always_comb begin
    if (val_i < LO)      clamped = LO;
    else if (val_i > HI) clamped = HI;
    else                 clamped = val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   settle_q <= RST;
    else if (we_i) settle_q <= clamped;
  end

  assign settle_o = settle_q;

  AST_SETTLE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_q >= LO) && (settle_q <= HI)); // R9
endmodule

// File: rtl/pg_cmd_decode.sv
module pg_cmd_decode #(
  parameter int N_UNITS = 6,
  parameter int UW      = 3
) (
  input  logic               issue_valid_i,
  input  logic [UW-1:0]      issue_unit_i,
  input  logic               sleep_valid_i,
  input  logic [UW-1:0]      sleep_unit_i,
  input  logic [N_UNITS-1:0] ready_i,
  output logic [N_UNITS-1:0] issue_hit_o,
  output logic [N_UNITS-1:0] sleep_hit_o,
  output logic               stall_o
);
  // indices beyond N_UNITS-1 match no unit
  for (genvar i = 0; i < N_UNITS; i++) begin : g_dec
    assign issue_hit_o[i] = issue_valid_i && (issue_unit_i == UW'(i));
    assign sleep_hit_o[i] = sleep_valid_i && (sleep_unit_i == UW'(i));
  end

  assign stall_o = |(issue_hit_o & ~ready_i);
endmodule

// File: rtl/pg_unit_ctrl.sv
module pg_unit_ctrl
  import pg_pkg::*;
#(
  parameter int IDLE_MIN   = 100,
  parameter int AUTO_LIMIT = 1000,
  parameter int SETTLE_W   = 4,
  localparam int IW        = $clog2(AUTO_LIMIT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_hit_i,
  input  logic                sleep_hit_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output pg_state_e           state_o,
  output logic                gate_en_o,
  output logic                ready_o
);
  localparam logic [IW-1:0] IDLE_TH = IW'(IDLE_MIN);
  localparam logic [IW-1:0] AUTO_TH = IW'(AUTO_LIMIT - 1);
  localparam logic [IW-1:0] IDLE_SAT = IW'(AUTO_LIMIT);

  pg_state_e           state_q, state_d;
  logic [IW-1:0]       idle_q, idle_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                pend_q, pend_d;
  logic                want_sleep;

  assign want_sleep = pend_q | sleep_hit_i;

  always_comb begin
    state_d = state_q;
    idle_d  = idle_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    unique case (state_q)
      PG_ON: begin
        if (issue_hit_i) begin
          idle_d = '0;
          pend_d = 1'b0;
        end else if ((want_sleep && idle_q >= IDLE_TH) || idle_q >= AUTO_TH) begin
          state_d = PG_GATED;
          idle_d  = '0;
          pend_d  = 1'b0;
        end else begin
          if (idle_q != IDLE_SAT) idle_d = idle_q + IW'(1);
          if (sleep_hit_i) pend_d = 1'b1;
        end
      end
      PG_GATED: begin
        if (issue_hit_i) begin
          state_d = PG_WAKING;
          cnt_d   = settle_i;
        end
      end
      PG_WAKING: begin
        if (cnt_q <= SETTLE_W'(1)) begin
          state_d = PG_ON;
          idle_d  = '0;
        end else begin
          cnt_d = cnt_q - SETTLE_W'(1);
        end
      end
      default: state_d = PG_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PG_ON;
      idle_q  <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o   = state_q;
  assign gate_en_o = (state_q != PG_GATED);
  assign ready_o   = (state_q == PG_ON);

  AST_GATE_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PG_ON) |=> (state_q != PG_GATED || $past(idle_q) >= IDLE_TH)); // R5
  AST_GATED_NOT_TO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PG_GATED) |=> (state_q != PG_ON)); // R7
  AST_WAKE_ON_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PG_GATED && issue_hit_i) |=> (state_q == PG_WAKING)); // R7
  AST_ISSUE_CLEARS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PG_ON && issue_hit_i) |=> (state_q == PG_ON && idle_q == '0)); // R3
  AST_WAKE_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PG_WAKING) |-> (cnt_q != '0)); // R9
  AST_IDLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= IDLE_SAT); // R3
endmodule

// File: rtl/alu_pg_ctrl.sv
module alu_pg_ctrl
  import pg_pkg::*;
#(
  parameter int N_ADD      = 4,
  parameter int N_MUL      = 2,
  parameter int IDLE_MIN   = 100,
  parameter int AUTO_LIMIT = 1000,
  parameter int SETTLE_W   = 4,
  parameter int SETTLE_MIN = 1,
  parameter int SETTLE_MAX = 10,
  parameter int SETTLE_RST = 4,
  localparam int N_UNITS   = N_ADD + N_MUL,
  localparam int UW        = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_valid_i,
  input  logic [UW-1:0]        issue_unit_i,
  input  logic                 sleep_valid_i,
  input  logic [UW-1:0]        sleep_unit_i,
  input  logic                 settle_we_i,
  input  logic [SETTLE_W-1:0]  settle_val_i,
  output logic [N_UNITS-1:0]   gate_en_o,
  output logic [N_UNITS-1:0]   ready_o,
  output logic [2*N_UNITS-1:0] unit_state_o,
  output logic                 stall_o
);
  logic [SETTLE_W-1:0] settle;
  logic [N_UNITS-1:0]  issue_hit, sleep_hit;

  pg_settle_reg #(
    .SETTLE_W  (SETTLE_W),
    .SETTLE_MIN(SETTLE_MIN),
    .SETTLE_MAX(SETTLE_MAX),
    .SETTLE_RST(SETTLE_RST)
  ) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (settle_we_i),
    .val_i   (settle_val_i),
    .settle_o(settle)
  );

  pg_cmd_decode #(
    .N_UNITS(N_UNITS),
    .UW     (UW)
  ) u_dec (
    .issue_valid_i(issue_valid_i),
    .issue_unit_i (issue_unit_i),
    .sleep_valid_i(sleep_valid_i),
    .sleep_unit_i (sleep_unit_i),
    .ready_i      (ready_o),
    .issue_hit_o  (issue_hit),
    .sleep_hit_o  (sleep_hit),
    .stall_o      (stall_o)
  );

  // adders occupy the low indices, multipliers follow
  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    pg_state_e st;
    pg_unit_ctrl #(
      .IDLE_MIN  (IDLE_MIN),
      .AUTO_LIMIT(AUTO_LIMIT),
      .SETTLE_W  (SETTLE_W)
    ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_hit_i(issue_hit[i]),
      .sleep_hit_i(sleep_hit[i]),
      .settle_i   (settle),
      .state_o    (st),
      .gate_en_o  (gate_en_o[i]),
      .ready_o    (ready_o[i])
    );
    assign unit_state_o[2*i +: 2] = st;
  end

  AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> issue_valid_i); // R8
  AST_ONE_ISSUE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_hit)); // R8
  AST_READY_IMPLIES_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~gate_en_o) == '0); // R6
endmodule

// File: tb/tb_alu_pg_ctrl.sv
module tb_alu_pg_ctrl;
  localparam int N  = 6;
  localparam int UW = 3;
  localparam int SW = 4;
  localparam int ST_ON = 0, ST_GATED = 1, ST_WAKING = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid = 1'b0;
  logic [UW-1:0] issue_unit = '0;
  logic          sleep_valid = 1'b0;
  logic [UW-1:0] sleep_unit = '0;
  logic          settle_we = 1'b0;
  logic [SW-1:0] settle_val = '0;
  logic [N-1:0]  gate_en, ready;
  logic [2*N-1:0] unit_state;
  logic          stall;

  alu_pg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_unit_i(issue_unit),
    .sleep_valid_i(sleep_valid), .sleep_unit_i(sleep_unit),
    .settle_we_i(settle_we), .settle_val_i(settle_val),
    .gate_en_o(gate_en), .ready_o(ready),
    .unit_state_o(unit_state), .stall_o(stall)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, act = 0;
  bit done = 1'b0;

  typedef struct {int at; int kind; int unit; int exp; string req;} item_t;
  item_t sb[$];

  task automatic push(int dt, int kind, int unit, int exp, string req);
    item_t it;
    it.at = cyc + dt; it.kind = kind; it.unit = unit; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_unit(int dt, int u, int st, string req);
    push(dt, 0, u, st, req);
    push(dt, 2, u, (st == ST_GATED) ? 0 : 1, {req, "/R6"});
    push(dt, 3, u, (st == ST_ON) ? 1 : 0, {req, "/R6"});
  endtask

  task automatic expect_stall(int dt, int v, string req);
    push(dt, 1, 0, v, req);
  endtask

  function automatic int actual(int kind, int u);
    case (kind)
      0:       return int'(unit_state[2*u +: 2]);
      1:       return int'(stall);
      2:       return int'(gate_en[u]);
      default: return int'(ready[u]);
    endcase
  endfunction

  // monitor: compare items due this cycle
  always @(posedge clk) begin
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        act = actual(sb[i].kind, sb[i].unit);
        n_chk++;
        if (act != sb[i].exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d unit %0d cycle %0d actual %0d expected %0d",
                   sb[i].req, sb[i].kind, sb[i].unit, cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic nb();
    @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) nb();
  endtask

  int r0, c, d, w, w2, q, i1;

  initial begin
    repeat (3) nb();
    for (int u = 0; u < N; u++) expect_unit(1, u, ST_ON, "R1");
    expect_stall(1, 0, "R1");
    nb();
    rst_ni = 1'b1;
    r0 = cyc;
    nb();

    // R5: early sleeps held until idle exceeds threshold; R2: others unaffected
    c = cyc;
    issue_valid = 1'b1; issue_unit = 3'd4; nb();
    issue_unit = 3'd5; nb();
    issue_valid = 1'b0; sleep_valid = 1'b1; sleep_unit = 3'd4; nb();
    sleep_unit = 3'd5; nb();
    sleep_valid = 1'b0;
    expect_unit(c + 101 - cyc, 4, ST_ON, "R5");
    expect_unit(c + 102 - cyc, 4, ST_GATED, "R5");
    expect_unit(c + 102 - cyc, 5, ST_ON, "R5");
    expect_unit(c + 103 - cyc, 5, ST_GATED, "R5");
    for (int u = 0; u < 4; u++) expect_unit(c + 103 - cyc, u, ST_ON, "R2");
    wait_until(c + 104);

    // R4: sleep on a long-idle unit acts at once
    d = cyc;
    sleep_valid = 1'b1; sleep_unit = 3'd0;
    expect_unit(1, 0, ST_GATED, "R4");
    expect_unit(1, 1, ST_ON, "R4");
    nb();
    // R10/R8: out-of-range indices
    issue_valid = 1'b1; issue_unit = 3'd6; sleep_unit = 3'd7;
    expect_stall(1, 0, "R8");
    expect_unit(1, 0, ST_GATED, "R10");
    expect_unit(1, 1, ST_ON, "R10");
    expect_unit(1, 4, ST_GATED, "R10");
    nb();
    issue_valid = 1'b0; sleep_valid = 1'b0;

    // R7/R8: wake with reset settling value 4
    w = cyc;
    issue_valid = 1'b1; issue_unit = 3'd4;
    for (int j = 1; j <= 4; j++) begin
      expect_unit(j, 4, ST_WAKING, "R7");
      expect_stall(j, 1, "R8");
    end
    expect_unit(5, 4, ST_ON, "R7");
    expect_stall(5, 0, "R8");
    nb();
    sleep_valid = 1'b1; sleep_unit = 3'd4;   // R10: ignored while waking
    nb();
    sleep_valid = 1'b0;
    repeat (3) nb();
    issue_valid = 1'b0;
    expect_unit(w + 5 + 102 - cyc, 4, ST_ON, "R10");

    // R9: clamp low to 1
    settle_we = 1'b1; settle_val = 4'd0; nb();
    settle_we = 1'b0;
    w2 = cyc;
    issue_valid = 1'b1; issue_unit = 3'd5;
    expect_unit(1, 5, ST_WAKING, "R9");
    expect_unit(2, 5, ST_ON, "R9");
    nb(); nb();
    issue_valid = 1'b0;

    // R9: clamp high to 10
    settle_we = 1'b1; settle_val = 4'd15; nb();
    settle_we = 1'b0;
    issue_valid = 1'b1; issue_unit = 3'd0;
    for (int j = 1; j <= 10; j++) expect_unit(j, 0, ST_WAKING, "R9");
    expect_unit(11, 0, ST_ON, "R9");
    expect_stall(10, 1, "R8");
    expect_stall(11, 0, "R8");
    repeat (11) nb();
    issue_valid = 1'b0;

    // R5: accepted issue cancels a pending sleep
    sleep_valid = 1'b1; sleep_unit = 3'd5; nb();
    sleep_valid = 1'b0;
    repeat (4) nb();
    q = cyc;
    issue_valid = 1'b1; issue_unit = 3'd5; nb();
    issue_unit = 3'd1; i1 = cyc; nb();
    issue_valid = 1'b0;
    expect_unit(q + 1 + 102 - cyc, 5, ST_ON, "R5");
    expect_unit(q + 1 + 110 - cyc, 5, ST_ON, "R5");

    // R3: automatic gating after AUTO_LIMIT idle edges, restart on issue
    wait_until(r0 + 998);
    expect_unit(1, 3, ST_ON, "R3");
    expect_unit(2, 3, ST_GATED, "R3");
    expect_unit(2, 2, ST_GATED, "R3");
    expect_unit(2, 1, ST_ON, "R3");
    wait_until(r0 + 1003);

    foreach (sb[k]) begin
      n_chk++; n_fail++;
      $display("FAIL %s: item for cycle %0d never compared actual %0d expected %0d",
               sb[k].req, sb[k].at, -1, sb[k].exp);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule